// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire PHY management bus (MDC clock and MDIO data) on behalf of a host. The host loads one 32-bit command word that packs the frame's start pattern, opcode, PHY address, register address, turnaround pattern and 16 data bits. Loading it launches a complete management frame. The block first sends a fixed 32-bit preamble of ones, then shifts the command word out MSB first.

For a read, the block releases MDIO from the turnaround field onward. It samples the PHY's 16 reply bits on rising MDC edges and writes them into the low half of the command register. Every finished frame sets a sticky completion flag, which the host clears by writing a one to it. A speed register sets how many system clocks each MDC phase lasts. A value of zero stops MDC, so a frame waits until a nonzero speed is loaded.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, the completion flag, the command register, the speed register and MDC are all zero, and MDIO is released (`mdio_oe` low).
- R2: A command write while idle stores `cmd_wdata` in the command register and raises busy on the next clock.
- R3: Every frame carries 64 bits: 32 ones first, then command bits 31 down to 0. Each bit is set up while MDC is low and holds across the following MDC rising edge.
- R4: Command bits [29:28] equal to 2'b10 select a read. A read releases MDIO for the last 18 bit times, from command bit 17 down to bit 0. Any other opcode drives all 64 bits.
- R5: On a read, the bits present on `mdio_in` at the last 16 MDC rising edges are collected MSB first. At completion they replace command register bits [15:0], and bits [31:16] keep the issued command.
- R6: With a speed value S > 0, each MDC high phase and each low phase lasts S system clock cycles.
- R7: While the speed value is zero, MDC does not toggle and a pending frame waits. A reset clears the speed value, so it must be reloaded before any frame can proceed.
- R8: Busy falls on the clock edge that ends the last bit, and the completion flag rises on that same edge.
- R9: An event write with `evt_wbit` = 1 clears the completion flag (the flag is bit 23 of the host event word). An event write with `evt_wbit` = 0 leaves it set.
- R10: A command write arriving while busy is ignored: the frame in flight and the stored command are unchanged.
- R11: MDC stays low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Packed command word |
| speed_wr | input | 1 | Speed register write strobe |
| speed_wdata | input | SPD_W | MDC phase length in system clocks |
| evt_wr | input | 1 | Event register write strobe |
| evt_wbit | input | 1 | Value written at the completion flag position (1 clears) |
| data_rd | output | 32 | Command register contents, with read data in bits [15:0] |
| evt_pending | output | 1 | Sticky completion flag |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value seen on the pin |

## Verification
The assertions check several rules on every cycle:
- MDIO is released during the read reply field.
- The preamble bits are ones.
- MDC is frozen with a zero speed and low when idle.
- The completion flag rises only as busy falls.
- A write while busy leaves the stored command alone.

Only the bench's scenarios can show the rest. That covers whole frames against the expected bit order, read data returning from a modelled PHY, the MDC phase length, recovery after loading a speed, and the clear-by-one rule.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W      = 32;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + CMD_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int OP_LSB     = 28;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam int TA_MSB     = 17;
  localparam int REL_POS    = PRE_BITS + (CMD_W - 1 - TA_MSB);
  localparam int RD_POS     = FRAME_BITS - DATA_W;

  function automatic logic frame_bit(input logic [CMD_W-1:0] cmd, input int pos);
    if (pos < PRE_BITS) return 1'b1;
    return cmd[FRAME_BITS - 1 - pos];
  endfunction

  function automatic logic drive_en(input logic rd, input int pos);
    return !(rd && pos >= REL_POS);
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SPD_W-1:0] spd,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [SPD_W-1:0] cnt;
  logic             tick;

  assign tick = en && (spd != '0) && (cnt >= spd - 1'b1);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (spd != '0) begin
      if (tick) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6
  mdc_phase_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> mdc);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_in,
  output logic              busy,
  output logic              finish,
  output logic              is_rd,
  output logic [DATA_W-1:0] rd_word,
  output logic              mdio_out,
  output logic              mdio_oe
);
  logic [CMD_W-1:0] cmd_q;
  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   nxt;

  assign nxt    = {1'b0, idx} + 1'b1;
  assign finish = busy && fall && (idx == IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      is_rd    <= 1'b0;
      cmd_q    <= '0;
      idx      <= '0;
      rd_word  <= '0;
      mdio_out <= 1'b1;
      mdio_oe  <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      cmd_q    <= cmd;
      is_rd    <= (cmd[OP_LSB+1:OP_LSB] == OP_READ);
      idx      <= '0;
      mdio_out <= frame_bit(cmd, 0);
      mdio_oe  <= 1'b1;
    end else if (busy) begin
      if (rise && is_rd && idx >= IDX_W'(RD_POS))
        rd_word <= {rd_word[DATA_W-2:0], mdio_in};
      if (finish) begin
        busy     <= 1'b0;
        mdio_out <= 1'b1;
        mdio_oe  <= 1'b0;
      end else if (fall) begin
        idx      <= nxt[IDX_W-1:0];
        mdio_out <= frame_bit(cmd_q, int'(nxt));
        mdio_oe  <= drive_en(is_rd, int'(nxt));
      end
    end
  end

  // R4
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    busy && is_rd && idx >= IDX_W'(REL_POS) |-> !mdio_oe);
  // R3
  preamble_ones_chk: assert property (@(posedge clk) disable iff (rst)
    busy && idx < IDX_W'(PRE_BITS) |-> mdio_out && mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_wdata,
  input  logic             speed_wr,
  input  logic [SPD_W-1:0] speed_wdata,
  input  logic             evt_wr,
  input  logic             evt_wbit,
  output logic [31:0]      data_rd,
  output logic             evt_pending,
  output logic             busy,
  output logic             mdc,
  output logic             mdio_out,
  output logic             mdio_oe,
  input  logic             mdio_in
);
  logic [SPD_W-1:0]  speed_q;
  logic              start, finish, is_rd, rise, fall;
  logic [DATA_W-1:0] rd_word;

  assign start = cmd_wr && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      speed_q     <= '0;
      data_rd     <= '0;
      evt_pending <= 1'b0;
    end else begin
      if (speed_wr) speed_q <= speed_wdata;
      if (start) data_rd <= cmd_wdata;
      else if (finish && is_rd) data_rd[DATA_W-1:0] <= rd_word;
      if (finish) evt_pending <= 1'b1;
      else if (evt_wr && evt_wbit) evt_pending <= 1'b0;
    end
  end

  mdio_mdc_gen #(.SPD_W(SPD_W)) clk_gen_i (
    .clk(clk), .rst(rst), .en(busy), .spd(speed_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_seq seq_i (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd_wdata),
    .rise(rise), .fall(fall), .mdio_in(mdio_in),
    .busy(busy), .finish(finish), .is_rd(is_rd), .rd_word(rd_word),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_wr |=> $stable(data_rd[31:16]));
  // R8
  evt_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_pending) |-> $fell(busy));
  // R7
  zero_speed_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    speed_q == '0 |=> $stable(mdc));
  // R11
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SPD_W = 6;

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, op, phy, rg, 2'b10, d};
  endfunction

  // {command, PHY reply}
  localparam logic [47:0] VEC [6] = '{
    {mk(2'b01, 5'h01, 5'h00, 16'h8000), 16'h0000},
    {mk(2'b10, 5'h01, 5'h01, 16'h0000), 16'h786D},
    {mk(2'b01, 5'h1F, 5'h04, 16'h01E1), 16'h0000},
    {mk(2'b10, 5'h00, 5'h1F, 16'h0000), 16'hA5A5},
    {mk(2'b10, 5'h15, 5'h02, 16'h0000), 16'h0001},
    {mk(2'b01, 5'h0A, 5'h14, 16'hFFFF), 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 1'b0, speed_wr = 1'b0, evt_wr = 1'b0, evt_wbit = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [SPD_W-1:0] speed_wdata = '0;
  logic [31:0] data_rd;
  logic evt_pending, busy, mdc, mdio_out, mdio_oe;
  logic mdio_in = 1'b1;

  int checks = 0, errors = 0, cyc = 0, rise_cnt = 0;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] resp_q = '0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.SPD_W(SPD_W)) dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .speed_wr(speed_wr), .speed_wdata(speed_wdata), .evt_wr(evt_wr),
    .evt_wbit(evt_wbit), .data_rd(data_rd), .evt_pending(evt_pending),
    .busy(busy), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .mdio_in(mdio_in)
  );

  // Frame monitor: records the pin state at every MDC rising edge
  always @(posedge mdc or posedge rst) begin
    if (rst) rise_cnt = 0;
    else begin
      cap_o[63 - (rise_cnt % 64)]  = mdio_out;
      cap_oe[63 - (rise_cnt % 64)] = mdio_oe;
      rise_cnt = rise_cnt + 1;
    end
  end

  // PHY model: presents reply bits after MDC falls in the reply field
  always @(negedge mdc or posedge rst) begin
    if (rst) mdio_in <= 1'b1;
    else if ((rise_cnt % 64) >= 48) mdio_in <= resp_q[63 - (rise_cnt % 64)];
    else mdio_in <= 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [31:0] c);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = c;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wr_speed(input logic [SPD_W-1:0] s);
    @(negedge clk); speed_wr = 1'b1; speed_wdata = s;
    @(negedge clk); speed_wr = 1'b0;
  endtask

  task automatic wr_evt(input logic b);
    @(negedge clk); evt_wr = 1'b1; evt_wbit = b;
    @(negedge clk); evt_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  function automatic logic is_read(input logic [31:0] c);
    return c[29:28] == 2'b10;
  endfunction

  task automatic check_frame(input string req, input logic [31:0] c);
    logic [63:0] exp_f, exp_oe;
    exp_f  = {32'hFFFF_FFFF, c};
    exp_oe = is_read(c) ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
    check({req, " oe pattern"}, cap_oe, exp_oe);
    check({req, " driven bits"}, cap_o & exp_oe, exp_f & exp_oe);
  endtask

  initial begin
    logic [31:0] c;
    logic [15:0] r;
    int hi, lo;
    logic moved;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 event", evt_pending, 0);
    check("R1 data", data_rd, 0);
    check("R1 mdc/oe", {mdc, mdio_oe}, 0);
    rst = 1'b0;

    for (int i = 0; i < 6; i++) begin
      c = VEC[i][47:16];
      r = VEC[i][15:0];
      resp_q = r;
      wr_speed(SPD_W'(1 + i % 3));
      wr_cmd(c);
      check("R2 busy after write", busy, 1);
      check("R2 data stored", data_rd, c);
      wait_idle();
      check("R8 busy/event at end", {busy, evt_pending}, 2'b01);
      check_frame("R3 R4 frame", c);
      check("R5 R11 data/mdc", {data_rd, mdc}, is_read(c) ? {c[31:16], r, 1'b0} : {c, 1'b0});
      wr_evt(1'b1);
    end

    // R6: phase lengths with speed 3
    wr_speed(6'd3);
    resp_q = 16'h0;
    wr_cmd(mk(2'b01, 5'h02, 5'h03, 16'h1234));
    while (!mdc) @(negedge clk);
    hi = 0; while (mdc) begin hi++; @(negedge clk); end
    lo = 0; while (!mdc) begin lo++; @(negedge clk); end
    check("R6 high phase", hi, 3);
    check("R6 low phase", lo, 3);
    wait_idle();
    wr_evt(1'b1);

    // R9: event cleared only by writing one
    wr_cmd(mk(2'b01, 5'h03, 5'h00, 16'h0000));
    wait_idle();
    wr_evt(1'b0);
    check("R9 write zero keeps flag", evt_pending, 1);
    wr_evt(1'b1);
    check("R9 write one clears flag", evt_pending, 0);

    // R10: write while busy ignored
    wr_speed(6'd1);
    c = mk(2'b01, 5'h04, 5'h05, 16'hBEEF);
    wr_cmd(c);
    repeat (20) @(negedge clk);
    wr_cmd(mk(2'b10, 5'h1E, 5'h1D, 16'h0000));
    wait_idle();
    check("R10 stored command", data_rd, c);
    check_frame("R10 frame unchanged", c);
    wr_evt(1'b1);

    // R7: zero speed stalls, reload resumes
    wr_speed(6'd0);
    c = mk(2'b01, 5'h06, 5'h07, 16'h0F0F);
    wr_cmd(c);
    moved = 1'b0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); if (mdc) moved = 1'b1; end
    check("R7 mdc frozen, busy held", {moved, busy}, 2'b01);
    wr_speed(6'd2);
    wait_idle();
    check("R7 resumes and completes", {busy, evt_pending}, 2'b01);
    check_frame("R7 frame after resume", c);

    // R1: reset mid-frame, then speed must be reloaded (R7)
    wr_cmd(mk(2'b10, 5'h08, 5'h09, 16'h0000));
    repeat (25) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-frame reset", {busy, evt_pending, mdc, mdio_oe, data_rd}, 0);
    wr_cmd(mk(2'b01, 5'h01, 5'h01, 16'h0001));
    moved = 1'b0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (mdc) moved = 1'b1; end
    check("R7 speed cleared by reset", {moved, busy}, 2'b01);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule